// File: doc/BRIEF.md
# Palette Framebuffer Register Bank

This block is the software-facing register bank of an indexed-colour framebuffer controller. A host reaches it with 32-bit word accesses on a byte address. It stores the display geometry, the scan-out start offset, a control word, the pointer location, a 256-entry colour lookup table, three pointer colours and a 512-word pointer bitmap. A downstream pixel pipeline reads these values from dedicated output pins. It fetches palette colours through a combinational lookup port.

The pixel bits-per-pixel value is decoded from a field of the control word. The interrupt line is set by a frame-complete pulse from the scan-out logic and is cleared by any host write. A write to one dedicated address returns every stored value to zero. Accepted addresses that carry no function (scan timing slots) are swallowed silently. Any other written address raises a one-cycle error flag.

Top module: `fbreg_top`

## Requirements
- R1: After reset every stored value is zero, so `irq`, `bad_access`, `rdata`, geometry, offset and pointer outputs are 0, and `bits_per_pixel` is 1 (depth code 0).
- R2: Byte addresses 0x800 to 0xFFF hold colour entries with index (addr-0x800)>>3. Write data bits 23:0 are stored as red 23:16, green 15:8 and blue 7:0, and bits 31:24 are dropped. The `pix_index`/`pix_rgb` port returns an entry in the same cycle. Host reads of this window return 0.
- R3: Byte addresses 0x508 to 0x51F hold three pointer colours with index (addr-0x508)>>3, packed the same way as R2. Reads return the 24-bit value with bits 31:24 zero.
- R4: Byte addresses 0x1000 to 0x1FFF hold 512 pointer bitmap words with index (addr-0x1000)>>3. Each word keeps write data bits 15:0, and reads return it zero-extended.
- R5: A write of v to 0x118 sets `disp_width` to v×4, and a read there returns width/4. A write of v to 0x150 sets `disp_height` to v/2 (rounded down), and a read there returns height×2.
- R6: The control word at 0x300 is fully read/write. Bit 10 drives `force_blank` and bit 23 drives `cursor_off`. Bits 22:20 give `bits_per_pixel` as follows: 0→1, 1→2, 2→4, 3→8, 4→15, 5→16, 6 and 7→0.
- R7: Writes to 0x400 set `top_offset` and writes to 0x638 set `cursor_pos`. Host reads of both addresses return 0.
- R8: Writes to 0x000, 0x108, 0x110, 0x120, 0x128, 0x130, 0x138, 0x140, 0x148, 0x158, 0x160, 0x168, 0x170 and 0x200 change nothing and flag nothing. A write to any unlisted address changes no state and raises `bad_access` in the following cycle only. Reads of unlisted addresses return 0.
- R9: A write to 0x100000 clears all tables, the control word, the offset, the pointer position and the geometry.
- R10: `frame_done` sets `irq` in the next cycle. Any write, including ignored and unmapped ones, clears it. When both occur in the same cycle, `irq` ends up set.
- R11: `rdata` changes only in the cycle after `rd_en` and holds otherwise. A read in the same cycle as a write to the same address returns the value from before that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe, one word per cycle |
| rd_en | input | 1 | Read strobe |
| addr | input | 21 | Byte address |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Registered read data |
| bad_access | output | 1 | One-cycle flag for an unmapped write |
| frame_done | input | 1 | Frame-complete pulse from scan-out |
| irq | output | 1 | Frame interrupt |
| pix_index | input | 8 | Colour table lookup index |
| pix_rgb | output | 24 | Colour table entry at `pix_index` |
| disp_width | output | 16 | Active width in pixels |
| disp_height | output | 16 | Active height in lines |
| top_offset | output | 32 | Scan-out start offset |
| cursor_pos | output | 32 | Pointer position word |
| bits_per_pixel | output | 5 | Decoded pixel depth, 0 when unsupported |
| force_blank | output | 1 | Blanking request |
| cursor_off | output | 1 | Pointer disable |

## Verification
A mis-steered write index or a wrong window boundary puts data in the wrong slot. That error shows up at the next lookup or read-back of the neighbouring entry, so the tests write distinct patterns at the first and last entries and read at aliased offsets. A scaling error in the geometry registers appears on `disp_width`/`disp_height` one cycle after the write. A depth decode fault appears on `bits_per_pixel` after the control write. A stale interrupt or read register shows up within one cycle as `irq` or `rdata` disagreeing with the last strobe. A soft clear that misses a table only shows when that table is read back after the clear, so every table is read after it.

// File: rtl/fbreg_pkg.sv
package fbreg_pkg;

  localparam int unsigned FB_AW = 21;

  localparam logic [FB_AW-1:0] PAL_LO  = 21'h000800;
  localparam logic [FB_AW-1:0] PAL_HI  = 21'h001000;
  localparam logic [FB_AW-1:0] CPAL_LO = 21'h000508;
  localparam logic [FB_AW-1:0] CPAL_HI = 21'h000520;
  localparam logic [FB_AW-1:0] PAT_LO  = 21'h001000;
  localparam logic [FB_AW-1:0] PAT_HI  = 21'h002000;
  localparam logic [FB_AW-1:0] HDISP_A = 21'h000118;
  localparam logic [FB_AW-1:0] VDISP_A = 21'h000150;
  localparam logic [FB_AW-1:0] CTL_A   = 21'h000300;
  localparam logic [FB_AW-1:0] TOP_A   = 21'h000400;
  localparam logic [FB_AW-1:0] CPOS_A  = 21'h000638;
  localparam logic [FB_AW-1:0] SRST_A  = 21'h100000;

  typedef enum logic [3:0] {
    RG_NONE,
    RG_PAL,
    RG_CPAL,
    RG_PAT,
    RG_HDISP,
    RG_VDISP,
    RG_CTL,
    RG_TOP,
    RG_CPOS,
    RG_SRST,
    RG_TIMING
  } fb_region_e;

  function automatic logic [4:0] bpp_of(input logic [2:0] code);
    logic [4:0] r;
    case (code)
      3'd0:    r = 5'd1;
      3'd1:    r = 5'd2;
      3'd2:    r = 5'd4;
      3'd3:    r = 5'd8;
      3'd4:    r = 5'd15;
      3'd5:    r = 5'd16;
      default: r = 5'd0;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/fbreg_decode.sv
module fbreg_decode
  import fbreg_pkg::*;
#(
  parameter int PAL_IW  = 8,
  parameter int CPAL_IW = 2,
  parameter int PAT_IW  = 9
) (
  input  logic [FB_AW-1:0]   addr,
  output fb_region_e         region,
  output logic [PAL_IW-1:0]  pal_idx,
  output logic [CPAL_IW-1:0] cpal_idx,
  output logic [PAT_IW-1:0]  pat_idx
);

  logic [FB_AW-1:0] pal_off, cpal_off, pat_off;

  always_comb begin
    pal_off  = (addr - PAL_LO) >> 3;
    cpal_off = (addr - CPAL_LO) >> 3;
    pat_off  = (addr - PAT_LO) >> 3;
  end

  assign pal_idx  = pal_off[PAL_IW-1:0];
  assign cpal_idx = cpal_off[CPAL_IW-1:0];
  assign pat_idx  = pat_off[PAT_IW-1:0];

  always_comb begin
    region = RG_NONE;
    if (addr >= PAL_LO && addr < PAL_HI) begin
      region = RG_PAL;
    end else if (addr >= PAT_LO && addr < PAT_HI) begin
      region = RG_PAT;
    end else if (addr >= CPAL_LO && addr < CPAL_HI) begin
      region = RG_CPAL;
    end else begin
      case (addr)
        HDISP_A: region = RG_HDISP;
        VDISP_A: region = RG_VDISP;
        CTL_A:   region = RG_CTL;
        TOP_A:   region = RG_TOP;
        CPOS_A:  region = RG_CPOS;
        SRST_A:  region = RG_SRST;
        21'h000000, 21'h000108, 21'h000110, 21'h000120, 21'h000128,
        21'h000130, 21'h000138, 21'h000140, 21'h000148, 21'h000158,
        21'h000160, 21'h000168, 21'h000170, 21'h000200:
                 region = RG_TIMING;
        default: region = RG_NONE;
      endcase
    end
  end

endmodule

// File: rtl/fbreg_table.sv
module fbreg_table #(
  parameter int N = 256,
  parameter int W = 24,
  parameter int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          we,
  input  logic [IW-1:0] widx,
  input  logic [W-1:0]  wdata,
  input  logic [IW-1:0] ridx,
  output logic [W-1:0]  rdata
);

  localparam int SLOTS = 2 ** IW;

  logic [W-1:0] slot [SLOTS];

  for (genvar i = 0; i < SLOTS; i++) begin : g_slot
    if (i < N) begin : g_real
      logic [W-1:0] q, d;
      logic         hit;

      always_comb begin
        hit = we && (widx == IW'(i));
        d   = q;
        if (clr) begin
          d = '0;
        end else if (hit) begin
          d = wdata;
        end
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          q <= '0;
        end else begin
          q <= d;
        end
      end

      assign slot[i] = q;
    end else begin : g_pad
      assign slot[i] = '0;
    end
  end

  assign rdata = slot[ridx];

  // R9: a soft clear empties the table
  assert_table_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (slot[0] == '0));

endmodule

// File: rtl/fbreg_scalars.sv
module fbreg_scalars
  import fbreg_pkg::*;
#(
  parameter int DW    = 32,
  parameter int DIM_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr,
  input  fb_region_e       region,
  input  logic [DW-1:0]    wdata,
  input  logic             frame_done,
  output logic [DW-1:0]    ctl,
  output logic [DW-1:0]    top,
  output logic [DW-1:0]    cpos,
  output logic [DIM_W-1:0] width,
  output logic [DIM_W-1:0] height,
  output logic             irq,
  output logic [4:0]       bpp,
  output logic             blank,
  output logic             curs_off
);

  localparam int BLANK_BIT = 10;
  localparam int DEPTH_LSB = 20;
  localparam int CURS_BIT  = 23;

  logic [DW-1:0]    ctl_d, top_d, cpos_d;
  logic [DIM_W-1:0] width_d, height_d;
  logic             irq_d;
  logic             clr;

  always_comb begin
    clr      = wr && (region == RG_SRST);
    ctl_d    = ctl;
    top_d    = top;
    cpos_d   = cpos;
    width_d  = width;
    height_d = height;
    if (clr) begin
      ctl_d    = '0;
      top_d    = '0;
      cpos_d   = '0;
      width_d  = '0;
      height_d = '0;
    end else if (wr) begin
      case (region)
        RG_CTL:   ctl_d    = wdata;
        RG_TOP:   top_d    = wdata;
        RG_CPOS:  cpos_d   = wdata;
        RG_HDISP: width_d  = {wdata[DIM_W-3:0], 2'b00};
        RG_VDISP: height_d = wdata[DIM_W:1];
        default:  ;
      endcase
    end
    irq_d = irq;
    if (wr)         irq_d = 1'b0;
    if (frame_done) irq_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl    <= '0;
      top    <= '0;
      cpos   <= '0;
      width  <= '0;
      height <= '0;
      irq    <= 1'b0;
    end else begin
      ctl    <= ctl_d;
      top    <= top_d;
      cpos   <= cpos_d;
      width  <= width_d;
      height <= height_d;
      irq    <= irq_d;
    end
  end

  assign bpp      = bpp_of(ctl[DEPTH_LSB+2:DEPTH_LSB]);
  assign blank    = ctl[BLANK_BIT];
  assign curs_off = ctl[CURS_BIT];

  assert_irq_set_R10: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done |=> irq);

  assert_irq_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && !frame_done) |=> !irq);

  assert_soft_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && region == RG_SRST) |=> (ctl == '0 && top == '0 && cpos == '0
                                   && width == '0 && height == '0));

  assert_width_scale_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && region == RG_HDISP) |=> (width[DIM_W-1:2] == $past(wdata[DIM_W-3:0])));

endmodule

// File: rtl/fbreg_top.sv
module fbreg_top
  import fbreg_pkg::*;
#(
  parameter int DW     = 32,
  parameter int DIM_W  = 16,
  parameter int PAL_N  = 256,
  parameter int CPAL_N = 3,
  parameter int PAT_N  = 512,
  parameter int PAT_W  = 16,
  parameter int RGB_W  = 24,
  parameter int PAL_IW = $clog2(PAL_N)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [FB_AW-1:0]  addr,
  input  logic [DW-1:0]     wdata,
  output logic [DW-1:0]     rdata,
  output logic              bad_access,
  input  logic              frame_done,
  output logic              irq,
  input  logic [PAL_IW-1:0] pix_index,
  output logic [RGB_W-1:0]  pix_rgb,
  output logic [DIM_W-1:0]  disp_width,
  output logic [DIM_W-1:0]  disp_height,
  output logic [DW-1:0]     top_offset,
  output logic [DW-1:0]     cursor_pos,
  output logic [4:0]        bits_per_pixel,
  output logic              force_blank,
  output logic              cursor_off
);

  localparam int CPAL_IW = $clog2(CPAL_N);
  localparam int PAT_IW  = $clog2(PAT_N);

  // reset: asserted at once, released on the clock
  logic rst_s1, rst_sn;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_s1 <= 1'b0;
      rst_sn <= 1'b0;
    end else begin
      rst_s1 <= 1'b1;
      rst_sn <= rst_s1;
    end
  end

  fb_region_e         region;
  logic [PAL_IW-1:0]  pal_idx;
  logic [CPAL_IW-1:0] cpal_idx;
  logic [PAT_IW-1:0]  pat_idx;

  fbreg_decode #(.PAL_IW(PAL_IW), .CPAL_IW(CPAL_IW), .PAT_IW(PAT_IW)) u_dec (
    .addr     (addr),
    .region   (region),
    .pal_idx  (pal_idx),
    .cpal_idx (cpal_idx),
    .pat_idx  (pat_idx)
  );

  logic soft_clr, we_pal, we_cpal, we_pat;
  always_comb begin
    soft_clr = wr_en && (region == RG_SRST);
    we_pal   = wr_en && (region == RG_PAL);
    we_cpal  = wr_en && (region == RG_CPAL);
    we_pat   = wr_en && (region == RG_PAT);
  end

  logic [RGB_W-1:0] cpal_rd;
  logic [PAT_W-1:0] pat_rd;

  fbreg_table #(.N(PAL_N), .W(RGB_W), .IW(PAL_IW)) u_pal (
    .clk (clk), .rst_n (rst_sn), .clr (soft_clr), .we (we_pal),
    .widx (pal_idx), .wdata (wdata[RGB_W-1:0]),
    .ridx (pix_index), .rdata (pix_rgb)
  );

  fbreg_table #(.N(CPAL_N), .W(RGB_W), .IW(CPAL_IW)) u_cpal (
    .clk (clk), .rst_n (rst_sn), .clr (soft_clr), .we (we_cpal),
    .widx (cpal_idx), .wdata (wdata[RGB_W-1:0]),
    .ridx (cpal_idx), .rdata (cpal_rd)
  );

  fbreg_table #(.N(PAT_N), .W(PAT_W), .IW(PAT_IW)) u_pat (
    .clk (clk), .rst_n (rst_sn), .clr (soft_clr), .we (we_pat),
    .widx (pat_idx), .wdata (wdata[PAT_W-1:0]),
    .ridx (pat_idx), .rdata (pat_rd)
  );

  logic [DW-1:0] ctl;

  fbreg_scalars #(.DW(DW), .DIM_W(DIM_W)) u_scl (
    .clk        (clk),
    .rst_n      (rst_sn),
    .wr         (wr_en),
    .region     (region),
    .wdata      (wdata),
    .frame_done (frame_done),
    .ctl        (ctl),
    .top        (top_offset),
    .cpos       (cursor_pos),
    .width      (disp_width),
    .height     (disp_height),
    .irq        (irq),
    .bpp        (bits_per_pixel),
    .blank      (force_blank),
    .curs_off   (cursor_off)
  );

  // read path and error flag
  logic [DW-1:0] rd_next, rdata_d;
  logic          bad_d;

  always_comb begin
    case (region)
      RG_CPAL:  rd_next = DW'(cpal_rd);
      RG_PAT:   rd_next = DW'(pat_rd);
      RG_HDISP: rd_next = DW'(disp_width >> 2);
      RG_VDISP: rd_next = DW'({disp_height, 1'b0});
      RG_CTL:   rd_next = ctl;
      default:  rd_next = '0;
    endcase
    rdata_d = rd_en ? rd_next : rdata;
    bad_d   = wr_en && (region == RG_NONE);
  end

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) begin
      rdata      <= '0;
      bad_access <= 1'b0;
    end else begin
      rdata      <= rdata_d;
      bad_access <= bad_d;
    end
  end

  assert_rdata_hold_R11: assert property (@(posedge clk) disable iff (!rst_sn)
    !rd_en |=> $stable(rdata));

  assert_unmapped_read_R8: assert property (@(posedge clk) disable iff (!rst_sn)
    (rd_en && region == RG_NONE) |=> (rdata == '0));

  assert_bad_cause_R8: assert property (@(posedge clk) disable iff (!rst_sn)
    bad_access |-> $past(wr_en));

  assert_bad_quiet_R8: assert property (@(posedge clk) disable iff (!rst_sn)
    (wr_en && region == RG_TIMING) |=> !bad_access);

  assert_ctl_read_R6: assert property (@(posedge clk) disable iff (!rst_sn)
    (rd_en && !wr_en && region == RG_CTL) |=> (rdata == $past(ctl)));

endmodule

// File: tb/fbreg_top_test.sv
module fbreg_top_test;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        wr_en, rd_en, frame_done;
  logic [20:0] addr;
  logic [31:0] wdata;
  logic [7:0]  pix_index;
  logic [31:0] rdata;
  logic        bad_access, irq, force_blank, cursor_off;
  logic [23:0] pix_rgb;
  logic [15:0] disp_width, disp_height;
  logic [31:0] top_offset, cursor_pos;
  logic [4:0]  bits_per_pixel;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  fbreg_top uut (
    .clk (clk), .rst_n (rst_n), .wr_en (wr_en), .rd_en (rd_en),
    .addr (addr), .wdata (wdata), .rdata (rdata), .bad_access (bad_access),
    .frame_done (frame_done), .irq (irq), .pix_index (pix_index),
    .pix_rgb (pix_rgb), .disp_width (disp_width), .disp_height (disp_height),
    .top_offset (top_offset), .cursor_pos (cursor_pos),
    .bits_per_pixel (bits_per_pixel), .force_blank (force_blank),
    .cursor_off (cursor_off)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [20:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [20:0] a, output logic [31:0] d);
    @(negedge clk);
    rd_en = 1'b1; addr = a;
    @(negedge clk);
    rd_en = 1'b0;
    d = rdata;
  endtask

  function automatic logic [4:0] exp_bpp(input int code);
    case (code)
      0: return 5'd1;  1: return 5'd2;  2: return 5'd4;
      3: return 5'd8;  4: return 5'd15; 5: return 5'd16;
      default: return 5'd0;
    endcase
  endfunction

  task automatic look(input logic [7:0] i, input logic [23:0] exp, input string req);
    pix_index = i;
    #1;
    chk(req, 32'(pix_rgb), 32'(exp));
  endtask

  task automatic t_reset_R1();
    logic [31:0] v;
    chk("R1 irq", 32'(irq), 0);
    chk("R1 bad_access", 32'(bad_access), 0);
    chk("R1 rdata", rdata, 0);
    chk("R1 width", 32'(disp_width), 0);
    chk("R1 height", 32'(disp_height), 0);
    chk("R1 top", top_offset, 0);
    chk("R1 cpos", cursor_pos, 0);
    chk("R1 bpp", 32'(bits_per_pixel), 1);
    look(8'd7, 24'h0, "R1 palette");
    rd(21'h300, v);
    chk("R1 ctl read", v, 0);
  endtask

  task automatic t_palette_R2();
    logic [31:0] v;
    wr(21'h800, 32'h00A1B2C3);
    wr(21'h808, 32'h00102030);
    wr(21'hFF8, 32'hEE445566);
    look(8'd0, 24'hA1B2C3, "R2 entry0");
    look(8'd1, 24'h102030, "R2 entry1");
    look(8'd255, 24'h445566, "R2 entry255");
    look(8'd2, 24'h000000, "R2 untouched entry2");
    wr(21'h80C, 32'h00777777);
    look(8'd1, 24'h777777, "R2 aliased offset");
    rd(21'h800, v);
    chk("R2 read is zero", v, 0);
  endtask

  task automatic t_cpal_R3();
    logic [31:0] v;
    wr(21'h508, 32'hFF112233);
    wr(21'h510, 32'h00445566);
    wr(21'h518, 32'h00778899);
    rd(21'h508, v); chk("R3 entry0", v, 32'h00112233);
    rd(21'h510, v); chk("R3 entry1", v, 32'h00445566);
    rd(21'h518, v); chk("R3 entry2", v, 32'h00778899);
  endtask

  task automatic t_pattern_R4();
    logic [31:0] v;
    wr(21'h1000, 32'hDEAD1234);
    wr(21'h1FF8, 32'h0000ABCD);
    wr(21'h1008, 32'h00005555);
    rd(21'h1000, v); chk("R4 word0", v, 32'h00001234);
    rd(21'h1004, v); chk("R4 word0 aliased", v, 32'h00001234);
    rd(21'h1FF8, v); chk("R4 word511", v, 32'h0000ABCD);
    rd(21'h1008, v); chk("R4 word1", v, 32'h00005555);
  endtask

  task automatic t_dims_R5();
    logic [31:0] v;
    wr(21'h118, 32'd160);
    chk("R5 width", 32'(disp_width), 640);
    rd(21'h118, v); chk("R5 width read", v, 160);
    wr(21'h150, 32'd961);
    chk("R5 height", 32'(disp_height), 480);
    rd(21'h150, v); chk("R5 height read", v, 960);
  endtask

  task automatic t_ctl_R6();
    logic [31:0] v;
    for (int c = 0; c < 8; c++) begin
      wr(21'h300, 32'(c) << 20);
      chk("R6 bpp", 32'(bits_per_pixel), 32'(exp_bpp(c)));
    end
    wr(21'h300, 32'h00800400);
    chk("R6 blank", 32'(force_blank), 1);
    chk("R6 cursor_off", 32'(cursor_off), 1);
    wr(21'h300, 32'h5A3FFBFF);
    chk("R6 blank low", 32'(force_blank), 0);
    chk("R6 cursor_off low", 32'(cursor_off), 0);
    chk("R6 bpp code3", 32'(bits_per_pixel), 8);
    rd(21'h300, v); chk("R6 full read", v, 32'h5A3FFBFF);
  endtask

  task automatic t_offsets_R7();
    logic [31:0] v;
    wr(21'h400, 32'h00012000);
    wr(21'h638, 32'h00040020);
    chk("R7 top", top_offset, 32'h00012000);
    chk("R7 cpos", cursor_pos, 32'h00040020);
    rd(21'h400, v); chk("R7 top read zero", v, 0);
    rd(21'h300, v);
    rd(21'h638, v); chk("R7 cpos read zero", v, 0);
  endtask

  task automatic t_ignore_R8();
    logic [31:0] v;
    logic [20:0] tl [14] = '{21'h000, 21'h108, 21'h110, 21'h120, 21'h128,
                             21'h130, 21'h138, 21'h140, 21'h148, 21'h158,
                             21'h160, 21'h168, 21'h170, 21'h200};
    for (int k = 0; k < 14; k++) begin
      wr(tl[k], 32'hFFFFFFFF);
      chk("R8 timing no flag", 32'(bad_access), 0);
    end
    chk("R8 width kept", 32'(disp_width), 640);
    chk("R8 height kept", 32'(disp_height), 480);
    chk("R8 top kept", top_offset, 32'h00012000);
    chk("R8 cpos kept", cursor_pos, 32'h00040020);
    rd(21'h300, v); chk("R8 ctl kept", v, 32'h5A3FFBFF);
    wr(21'h100, 32'hFFFFFFFF);
    chk("R8 unmapped flag", 32'(bad_access), 1);
    @(negedge clk);
    chk("R8 flag one cycle", 32'(bad_access), 0);
    rd(21'h300, v); chk("R8 ctl after unmapped", v, 32'h5A3FFBFF);
    rd(21'h104, v); chk("R8 unmapped read", v, 0);
    chk("R8 bpp kept", 32'(bits_per_pixel), 8);
  endtask

  task automatic t_irq_R10();
    @(negedge clk); frame_done = 1'b1;
    @(negedge clk); frame_done = 1'b0;
    chk("R10 raised", 32'(irq), 1);
    repeat (3) @(negedge clk);
    chk("R10 held", 32'(irq), 1);
    wr(21'h128, 32'h0);
    chk("R10 cleared by ignored write", 32'(irq), 0);
    @(negedge clk);
    wr_en = 1'b1; addr = 21'h000; wdata = 0; frame_done = 1'b1;
    @(negedge clk);
    wr_en = 1'b0; frame_done = 1'b0;
    chk("R10 simultaneous", 32'(irq), 1);
    wr(21'h104, 32'h0);
    chk("R10 cleared by unmapped write", 32'(irq), 0);
  endtask

  task automatic t_read_R11();
    logic [31:0] v;
    wr(21'h300, 32'h00000011);
    @(negedge clk);
    rd_en = 1'b1; addr = 21'h300;
    #1;
    chk("R11 no early change", rdata, 0);
    @(negedge clk);
    rd_en = 1'b0;
    chk("R11 one-cycle latency", rdata, 32'h00000011);
    @(negedge clk);
    rd_en = 1'b1; wr_en = 1'b1; addr = 21'h300; wdata = 32'h00000022;
    @(negedge clk);
    rd_en = 1'b0; wr_en = 1'b0;
    chk("R11 old value on same-cycle write", rdata, 32'h00000011);
    wr(21'h300, 32'h00000033);
    repeat (2) @(negedge clk);
    chk("R11 hold", rdata, 32'h00000011);
    rd(21'h300, v); chk("R11 new value", v, 32'h00000033);
  endtask

  task automatic t_clear_R9();
    logic [31:0] v;
    @(negedge clk); frame_done = 1'b1;
    @(negedge clk); frame_done = 1'b0;
    wr(21'h100000, 32'h0);
    chk("R9 irq", 32'(irq), 0);
    chk("R9 width", 32'(disp_width), 0);
    chk("R9 height", 32'(disp_height), 0);
    chk("R9 top", top_offset, 0);
    chk("R9 cpos", cursor_pos, 0);
    chk("R9 bpp", 32'(bits_per_pixel), 1);
    chk("R9 bad flag", 32'(bad_access), 0);
    look(8'd0, 24'h0, "R9 palette0");
    look(8'd255, 24'h0, "R9 palette255");
    rd(21'h510, v); chk("R9 cursor palette", v, 0);
    rd(21'h1FF8, v); chk("R9 pattern", v, 0);
    rd(21'h300, v); chk("R9 ctl", v, 0);
  endtask

  task automatic finish_run();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog actual=hung expected=done");
    finish_run();
  end

  initial begin
    rst_n = 1'b0; wr_en = 1'b0; rd_en = 1'b0; frame_done = 1'b0;
    addr = '0; wdata = '0; pix_index = '0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    repeat (3) @(negedge clk);
    t_reset_R1();
    t_palette_R2();
    t_cpal_R3();
    t_pattern_R4();
    t_dims_R5();
    t_ctl_R6();
    t_offsets_R7();
    t_ignore_R8();
    t_irq_R10();
    t_read_R11();
    t_clear_R9();
    finish_run();
  end

endmodule